// File: doc/BRIEF.md
# Network-Side Loop Activation Controller

This block runs the activation handshake on the network-termination side of a four-wire subscriber loop. An analog detector outside the block classifies the signal arriving from the terminal into a 2-bit code. The block registers that code, steps a three-state activation machine, and reports which line signal the transmitter should send: the idle signal (INFO 0), the wake-up signal (INFO 2) or the fully framed active signal (INFO 4). Each change of the received code raises an interrupt flag. A read strobe clears the flag.

A host controls the block through one 8-bit control/status register. Two inhibit bits let the host hold activation at either of two points until another link is ready. With the first inhibit set, the block stays idle when the terminal asks to wake up. With the second inhibit set, the block keeps sending the wake-up signal and does not go to the active signal. The same register holds an external-loopback enable and a 96 kHz test-tone enable, and these drive output pins. When the device is strapped as a terminal instead of a network end, the register reads as all zeros.

Top module: `nt_activation_ctrl`

## Requirements
- R1: When regWrData bit 7 (wake-up inhibit) has been written as 1 and the block is idle (txInfo 00), a received INFO 1 leaves txInfo at 00 for as long as the bit stays 1.
- R2: irq becomes 1 at the clock edge where the registered received code takes a value different from its previous value. This also holds while the wake-up inhibit is set. irq is cleared by regRdEn at a clock edge. If a new change arrives at the same edge as the read, irq stays set.
- R3: When bit 6 (activation inhibit) is 1 and txInfo is INFO 2 (01), a received INFO 3 leaves txInfo at 01 until the bit is cleared.
- R4: regRdData[5:4] holds the registered received code: 00 = INFO 0, 01 = INFO 1, 10 = INFO 3, 11 = illegal. regRdData[3:2] holds the transmitted code: 00 = INFO 0, 01 = INFO 2, 10 = INFO 4. The code 11 never appears on txInfo. regRdData[7:6] read back the two inhibits.
- R5: With no inhibits set, txInfo goes from 00 to 01 on INFO 1, from 01 to 10 on INFO 3, and from 10 to 00 on INFO 0. rxSig is registered at one clock edge, and txInfo changes at the following edge.
- R6: If an inhibit is cleared while its matching received code is still present, txInfo advances at the second clock edge after the write strobe, and no new received change is needed.
- R7: Writing bits 1 and 0 drives loopbackEn and testToneEn from the next clock edge. Both bits read back at regRdData[1:0].
- R8: An active-low rstN, or a synchronous softReset, clears the inhibits, the loopback and tone enables, the received code, txInfo and irq.
- R9: While teMode is 1, regRdData reads 0.
- R10: A received illegal code (11) raises irq but does not change txInfo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| softReset | input | 1 | Synchronous reset from the host |
| teMode | input | 1 | 1 when the device is strapped as a terminal |
| rxSig | input | 2 | Code classified by the line detector |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdEn | input | 1 | Status read strobe; clears irq |
| regRdData | output | 8 | Register read data |
| txInfo | output | 2 | Line signal to transmit |
| irq | output | 1 | Received-state change flag |
| loopbackEn | output | 1 | External loopback enable |
| testToneEn | output | 1 | 96 kHz test signal enable |

## Verification
The bench holds a received INFO 1 and a received INFO 3 under each inhibit for several cycles. A design that reacted early would leave idle, or would move past the wake-up signal too soon. The bench then clears each inhibit with the request still present and expects the advance at exactly the second edge. A design that waited for a new received edge would stay stuck at that point. The bench also checks that irq is raised while the wake-up inhibit blocks the state machine, checks that an illegal code raises irq without moving txInfo, and checks that a soft reset wipes a half-activated loop. It confirms that terminal mode hides a register that is otherwise fully populated.

// File: rtl/nt_act_pkg.sv
package nt_act_pkg;
  localparam int INFO_W  = 2;
  localparam int REG_W   = 8;
  localparam int BIT_INH1 = 7;
  localparam int BIT_INH3 = 6;
  localparam int RX_LSB   = 4;
  localparam int TX_LSB   = 2;
  localparam int BIT_LOOP = 1;
  localparam int BIT_TONE = 0;

  typedef enum logic [INFO_W-1:0] {
    RX_INFO0   = 2'b00,
    RX_INFO1   = 2'b01,
    RX_INFO3   = 2'b10,
    RX_ILLEGAL = 2'b11
  } rxInfo_e;

  typedef enum logic [INFO_W-1:0] {
    TX_INFO0 = 2'b00,
    TX_INFO2 = 2'b01,
    TX_INFO4 = 2'b10,
    TX_RSVD  = 2'b11
  } txInfo_e;

  typedef struct packed {
    logic cfgWrite;
    logic statusRead;
  } hostStrobe_t;
endpackage

// File: rtl/nt_act_datapath.sv
module nt_act_datapath
  import nt_act_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              softReset,
  input  logic              teMode,
  input  hostStrobe_t       strobe,
  input  logic [REG_W-1:0]  wrData,
  input  logic [INFO_W-1:0] rxSig,
  input  txInfo_e           txState,
  output rxInfo_e           rxState,
  output logic              inh1,
  output logic              inh3,
  output logic              loopbackEn,
  output logic              testToneEn,
  output logic              irq,
  output logic [REG_W-1:0]  rdData
);
  rxInfo_e rxNext;
  logic    rxChange;

  assign rxNext   = rxInfo_e'(rxSig);
  assign rxChange = (rxNext != rxState);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_INFO0;
      irq     <= 1'b0;
    end else if (softReset) begin
      rxState <= RX_INFO0;
      irq     <= 1'b0;
    end else begin
      rxState <= rxNext;
      if (rxChange)
        irq <= 1'b1;
      else if (strobe.statusRead)
        irq <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inh1       <= 1'b0;
      inh3       <= 1'b0;
      loopbackEn <= 1'b0;
      testToneEn <= 1'b0;
    end else if (softReset) begin
      inh1       <= 1'b0;
      inh3       <= 1'b0;
      loopbackEn <= 1'b0;
      testToneEn <= 1'b0;
    end else if (strobe.cfgWrite) begin
      inh1       <= wrData[BIT_INH1];
      inh3       <= wrData[BIT_INH3];
      loopbackEn <= wrData[BIT_LOOP];
      testToneEn <= wrData[BIT_TONE];
    end
  end

  always_comb begin
    rdData = '0;
    if (!teMode) begin
      rdData[BIT_INH1]                 = inh1;
      rdData[BIT_INH3]                 = inh3;
      rdData[RX_LSB +: INFO_W]         = rxState;
      rdData[TX_LSB +: INFO_W]         = txState;
      rdData[BIT_LOOP]                 = loopbackEn;
      rdData[BIT_TONE]                 = testToneEn;
    end
  end
endmodule

// File: rtl/nt_act_control.sv
module nt_act_control
  import nt_act_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        softReset,
  input  logic        teMode,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  rxInfo_e     rxState,
  input  logic        inh1,
  input  logic        inh3,
  output hostStrobe_t strobe,
  output txInfo_e     txState
);
  txInfo_e txNext;

  always_comb begin
    strobe.cfgWrite   = regWrEn;
    strobe.statusRead = regRdEn & ~teMode;
  end

  always_comb begin
    txNext = txState;
    unique case (txState)
      TX_INFO0: if (rxState == RX_INFO1 && !inh1) txNext = TX_INFO2;
      TX_INFO2: if (rxState == RX_INFO3 && !inh3) txNext = TX_INFO4;
      TX_INFO4: if (rxState == RX_INFO0)          txNext = TX_INFO0;
      default:                                    txNext = TX_INFO0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          txState <= TX_INFO0;
    else if (softReset) txState <= TX_INFO0;
    else                txState <= txNext;
  end
endmodule

// File: rtl/nt_activation_ctrl.sv
module nt_activation_ctrl
  import nt_act_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              softReset,
  input  logic              teMode,
  input  logic [INFO_W-1:0] rxSig,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              regRdEn,
  output logic [REG_W-1:0]  regRdData,
  output logic [INFO_W-1:0] txInfo,
  output logic              irq,
  output logic              loopbackEn,
  output logic              testToneEn
);
  hostStrobe_t strobeW;
  rxInfo_e     rxStateW;
  txInfo_e     txStateW;
  logic        inh1W;
  logic        inh3W;

  nt_act_control u_control (
    .clk(clk), .rstN(rstN), .softReset(softReset), .teMode(teMode),
    .regWrEn(regWrEn), .regRdEn(regRdEn),
    .rxState(rxStateW), .inh1(inh1W), .inh3(inh3W),
    .strobe(strobeW), .txState(txStateW)
  );

  nt_act_datapath u_datapath (
    .clk(clk), .rstN(rstN), .softReset(softReset), .teMode(teMode),
    .strobe(strobeW), .wrData(regWrData), .rxSig(rxSig),
    .txState(txStateW), .rxState(rxStateW),
    .inh1(inh1W), .inh3(inh3W),
    .loopbackEn(loopbackEn), .testToneEn(testToneEn),
    .irq(irq), .rdData(regRdData)
  );

  assign txInfo = txStateW;
endmodule

// File: rtl/nt_act_checker.sv
module nt_act_checker (
  input logic       clk,
  input logic       rstN,
  input logic       softReset,
  input logic       teMode,
  input logic [1:0] rxSig,
  input logic [1:0] rxState,
  input logic [1:0] txInfo,
  input logic       inh1,
  input logic       inh3,
  input logic       irq,
  input logic [7:0] regRdData
);
  AST_INH1_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (txInfo == 2'b00 && inh1 && !softReset) |=> (txInfo == 2'b00)); // R1

  AST_IRQ_ON_RX_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (!softReset && rxSig != rxState) |=> irq); // R2

  AST_INH3_HOLDS_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (txInfo == 2'b01 && inh3 && !softReset) |=> (txInfo == 2'b01)); // R3

  AST_TX_NOT_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
    txInfo != 2'b11); // R4

  AST_ADVANCE_TO_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (txInfo == 2'b01 && rxState == 2'b10 && !inh3 && !softReset) |=> (txInfo == 2'b10)); // R6

  AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    softReset |=> (txInfo == 2'b00 && !irq && !inh1 && !inh3)); // R8

  AST_TE_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    teMode |-> (regRdData == 8'h00)); // R9

  AST_ILLEGAL_NO_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == 2'b11 && !softReset) |=> $stable(txInfo)); // R10
endmodule

bind nt_activation_ctrl nt_act_checker u_chk (
  .clk(clk), .rstN(rstN), .softReset(softReset), .teMode(teMode),
  .rxSig(rxSig), .rxState(rxStateW), .txInfo(txInfo),
  .inh1(inh1W), .inh3(inh3W), .irq(irq), .regRdData(regRdData)
);

// File: tb/nt_activation_ctrl_bench.sv
module nt_activation_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       softReset = 1'b0;
  logic       teMode = 1'b0;
  logic [1:0] rxSig = 2'b00;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic       regRdEn = 1'b0;
  logic [7:0] regRdData;
  logic [1:0] txInfo;
  logic       irq;
  logic       loopbackEn;
  logic       testToneEn;

  int checkCount = 0;
  int failCount  = 0;

  nt_activation_ctrl u_nt_activation_ctrl (
    .clk(clk), .rstN(rstN), .softReset(softReset), .teMode(teMode),
    .rxSig(rxSig), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData), .txInfo(txInfo),
    .irq(irq), .loopbackEn(loopbackEn), .testToneEn(testToneEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] d);
    regWrData = d; regWrEn = 1'b1;
    step(1);
    regWrEn = 1'b0;
  endtask

  task automatic readClear();
    regRdEn = 1'b1;
    step(1);
    regRdEn = 1'b0;
  endtask

  task automatic testReset();
    check(regRdData == 8'h00, "R8 reset reg", regRdData, 0);
    check(txInfo == 2'b00, "R8 reset tx", txInfo, 0);
    check(irq == 1'b0, "R8 reset irq", irq, 0);
  endtask

  task automatic testSequence();
    rxSig = 2'b01; step(1);
    check(regRdData[5:4] == 2'b01, "R4 rx field INFO1", regRdData[5:4], 1);
    check(irq == 1'b1, "R2 irq on change", irq, 1);
    check(txInfo == 2'b00, "R5 tx one edge late", txInfo, 0);
    step(1);
    check(txInfo == 2'b01, "R5 tx INFO2", txInfo, 1);
    check(regRdData[3:2] == 2'b01, "R4 tx field", regRdData[3:2], 1);
    rxSig = 2'b10; step(2);
    check(txInfo == 2'b10, "R5 tx INFO4", txInfo, 2);
    rxSig = 2'b00; step(2);
    check(txInfo == 2'b00, "R5 back to INFO0", txInfo, 0);
    readClear();
    check(irq == 1'b0, "R2 read clears irq", irq, 0);
  endtask

  task automatic testInhibit1();
    writeReg(8'h80);
    check(regRdData[7] == 1'b1, "R1 inhibit readback", regRdData[7], 1);
    rxSig = 2'b01; step(5);
    check(txInfo == 2'b00, "R1 held idle", txInfo, 0);
    check(irq == 1'b1, "R2 irq under inhibit", irq, 1);
    regWrData = 8'h00; regWrEn = 1'b1; step(1); regWrEn = 1'b0;
    check(txInfo == 2'b00, "R6 not yet", txInfo, 0);
    step(1);
    check(txInfo == 2'b01, "R6 advance after clear", txInfo, 1);
  endtask

  task automatic testInhibit3();
    writeReg(8'h40);
    rxSig = 2'b10; step(5);
    check(txInfo == 2'b01, "R3 held at INFO2", txInfo, 1);
    check(regRdData[7:6] == 2'b01, "R3 inhibit readback", regRdData[7:6], 1);
    regWrData = 8'h00; regWrEn = 1'b1; step(1); regWrEn = 1'b0;
    check(txInfo == 2'b01, "R6 not yet", txInfo, 1);
    step(1);
    check(txInfo == 2'b10, "R6 advance to INFO4", txInfo, 2);
  endtask

  task automatic testIllegal();
    readClear();
    rxSig = 2'b11; step(1);
    check(irq == 1'b1, "R10 irq on illegal", irq, 1);
    check(regRdData[5:4] == 2'b11, "R4 rx illegal code", regRdData[5:4], 3);
    step(3);
    check(txInfo == 2'b10, "R10 tx unchanged", txInfo, 2);
    rxSig = 2'b00; regRdEn = 1'b1; step(1); regRdEn = 1'b0;
    check(irq == 1'b1, "R2 set wins over read", irq, 1);
    step(1);
    check(txInfo == 2'b00, "R5 deactivate", txInfo, 0);
  endtask

  task automatic testControls();
    writeReg(8'h03);
    check(loopbackEn == 1'b1 && testToneEn == 1'b1, "R7 both enables", {loopbackEn, testToneEn}, 3);
    check(regRdData[1:0] == 2'b11, "R7 readback", regRdData[1:0], 3);
    writeReg(8'h01);
    check(loopbackEn == 1'b0 && testToneEn == 1'b1, "R7 tone only", {loopbackEn, testToneEn}, 1);
  endtask

  task automatic testTeMode();
    writeReg(8'hC3);
    teMode = 1'b1; step(1);
    check(regRdData == 8'h00, "R9 TE reads zero", regRdData, 0);
    teMode = 1'b0; step(1);
    check(regRdData == 8'hC3, "R9 NT reads back", regRdData, 8'hC3);
    writeReg(8'h00);
  endtask

  task automatic testSoftReset();
    writeReg(8'h03);
    rxSig = 2'b01; step(2);
    check(txInfo == 2'b01, "R8 pending before reset", txInfo, 1);
    rxSig = 2'b00; softReset = 1'b1; step(1); softReset = 1'b0;
    check(txInfo == 2'b00, "R8 soft reset tx", txInfo, 0);
    check(regRdData == 8'h00, "R8 soft reset reg", regRdData, 0);
    check(irq == 1'b0 && loopbackEn == 1'b0, "R8 soft reset flags", {irq, loopbackEn}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    step(2);
    rstN = 1'b1;
    step(1);
    testReset();
    testSequence();
    testInhibit1();
    testInhibit3();
    testIllegal();
    testControls();
    testTeMode();
    testSoftReset();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule